// File: doc/BRIEF.md
# Vector Element Chaining Controller

This block schedules a short chain of dependent vector instructions across separate pipelined functional units. A typical chain is a load, then a multiply, then a store. Each unit handles one element per cycle. A consuming unit does not wait for its source vector to be complete. It starts on element i as soon as the unit before it has produced element i. Each unit has its own two read ports and one write port on the vector register file, so chained units never compete for register-file bandwidth.

A chain command arrives over a valid/ready handshake. It carries a vector length, a chaining mode, and a source and destination register index for every unit. A unit depends on the unit before it when its source index equals that unit's destination index. Back-pressure is simple. `cmd_ready` is high only while no chain is in flight. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. A command offered while the block is busy stays pending and has no effect until `cmd_ready` returns.

The mode selects how each consumer gets its operand:

- Bypass mode: the consumer takes the producer's result from the forwarding path in the cycle it emerges.
- Register-file mode: the consumer waits until the result has been written, then reads it back. This costs one extra cycle per hop.

Each unit drives an issue strobe with an element index, an operand-source select, and a write-back strobe with an element index.

Top module: `vchain_ctrl`

## Requirements
- R1: After reset, `cmd_ready` is 1 and every `fu_issue`, `fu_byp` and `fu_wb` bit is 0.
- R2: A command is accepted on a cycle with `cmd_valid` and `cmd_ready` both 1. From the next cycle, `cmd_ready` is 0. `cmd_ready` returns to 1 exactly two cycles after the last write-back strobe of the chain. No unit issues or writes back while `cmd_ready` is 1.
- R3: Unit 0 issues elements 0, 1, …, VL-1 on consecutive cycles. It starts the cycle after acceptance and drives `fu_byp[0]` = 0.
- R4: In bypass mode (`cmd_mode` = 1), a dependent unit k issues element i in the same cycle that unit k-1 raises its write-back strobe for element i, and drives `fu_byp[k]` = 1. With the default latency of 3, element 0 of unit 1 issues three cycles after element 0 of unit 0.
- R5: In register-file mode (`cmd_mode` = 0), a dependent unit issues element i one cycle after the producer's write-back of element i, and drives `fu_byp` = 0.
- R6: Unit k (k ≥ 1) is independent when its source index, `cmd_src[k*RW +: RW]`, differs from the destination index of unit k-1, `cmd_dst[(k-1)*RW +: RW]`. An independent unit issues elements 0..VL-1 from the cycle after acceptance, with `fu_byp` = 0.
- R7: Each unit raises `fu_wb` exactly LAT cycles after issuing an element. `fu_wb_elem` carries that element's index.
- R8: Within each unit, elements issue in ascending order, at most one per cycle. A dependent unit never issues an element before its producer has made it available. The third unit in a chain follows the second by the same rule.
- R9: A `cmd_vl` above VLMAX is treated as VLMAX. A `cmd_vl` of 0 issues nothing, and `cmd_ready` returns two cycles after acceptance.
- R10: A command held on `cmd_valid` while `cmd_ready` is 0 does not alter the running schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Chain command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_vl | input | VLW | Vector length for the chain |
| cmd_mode | input | 1 | 1 = bypass chaining, 0 = register-file chaining |
| cmd_src | input | NFU*RW | Source register index per unit, unit k at [k*RW +: RW] |
| cmd_dst | input | NFU*RW | Destination register index per unit, unit k at [k*RW +: RW] |
| fu_issue | output | NFU | Per-unit element issue strobe |
| fu_elem | output | NFU*EW | Element index being issued, unit k at [k*EW +: EW] |
| fu_byp | output | NFU | Operand of the issuing element comes from the forwarding path |
| fu_wb | output | NFU | Per-unit register-file write strobe |
| fu_wb_elem | output | NFU*EW | Element index being written, unit k at [k*EW +: EW] |

## Verification
A stale bit in the per-element written board lets a consumer run ahead of its producer, or stalls it forever. The first case shows at the ports as a consumer issue with no matching producer write-back before or in that cycle. The second shows as `cmd_ready` never returning. A wrong element counter or pipeline stage shows within LAT cycles, as a write-back whose element index is out of sequence. A dependency or mode captured wrongly at acceptance moves the first consumer issue by at least one cycle, so it is visible within LAT+1 cycles of the handshake.

// File: rtl/vchain_pkg.sv
package vchain_pkg;
  typedef enum logic {CHAIN_RF = 1'b0, CHAIN_BYP = 1'b1} chain_mode_e;
endpackage

// File: rtl/vchain_pipe.sv
// Result pipeline of one functional unit: carries a valid flag and element index.
module vchain_pipe #(
  parameter int LAT = 3,
  parameter int EW  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_v,
  input  logic [EW-1:0] in_e,
  output logic          out_v,
  output logic [EW-1:0] out_e,
  output logic          any_v
);
  logic [LAT-1:0] v_q;
  logic [EW-1:0]  e_q [LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) v_q <= '0;
    else begin
      v_q[0] <= in_v;
      for (int s = 1; s < LAT; s++) v_q[s] <= v_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    e_q[0] <= in_e;
    for (int s = 1; s < LAT; s++) e_q[s] <= e_q[s-1];
  end

  assign out_v = v_q[LAT-1];
  assign out_e = e_q[LAT-1];
  assign any_v = |v_q;
endmodule

// File: rtl/vchain_board.sv
// Per-element "written" bits for one producer's destination vector.
module vchain_board #(
  parameter int VLMAX = 8,
  parameter int EW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          set_v,
  input  logic [EW-1:0] set_e,
  input  logic [EW-1:0] rd_e,
  output logic          rd_bit
);
  logic [VLMAX-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     bits_q <= '0;
    else if (clr)   bits_q <= '0;
    else if (set_v) bits_q[set_e] <= 1'b1;
  end

  assign rd_bit = bits_q[rd_e];
endmodule

// File: rtl/vchain_unit_seq.sv
// Element sequencer of one functional unit plus its result pipeline.
module vchain_unit_seq #(
  parameter int VLMAX = 8,
  parameter int LAT   = 3,
  parameter int EW    = 3,
  parameter int VLW   = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           en,
  input  logic [VLW-1:0] vl,
  input  logic           go,
  output logic           issue,
  output logic [EW-1:0]  elem,
  output logic           all_issued,
  output logic           wb_v,
  output logic [EW-1:0]  wb_e,
  output logic           pipe_busy
);
  logic [VLW-1:0] cnt_q;

  assign issue      = en && (cnt_q < vl) && go;
  assign elem       = cnt_q[EW-1:0];
  assign all_issued = (cnt_q == vl);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (start) cnt_q <= '0;
    else if (issue) cnt_q <= cnt_q + VLW'(1);
  end

  vchain_pipe #(.LAT(LAT), .EW(EW)) pipe_i (
    .clk(clk), .rst_n(rst_n), .in_v(issue), .in_e(elem),
    .out_v(wb_v), .out_e(wb_e), .any_v(pipe_busy)
  );
endmodule

// File: rtl/vchain_ctrl.sv
module vchain_ctrl
  import vchain_pkg::*;
#(
  parameter int NFU   = 3,
  parameter int VLMAX = 8,
  parameter int LAT   = 3,
  parameter int RW    = 5,
  localparam int EW   = (VLMAX > 1) ? $clog2(VLMAX) : 1,
  localparam int VLW  = $clog2(VLMAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [VLW-1:0]    cmd_vl,
  input  logic              cmd_mode,
  input  logic [NFU*RW-1:0] cmd_src,
  input  logic [NFU*RW-1:0] cmd_dst,
  output logic [NFU-1:0]    fu_issue,
  output logic [NFU*EW-1:0] fu_elem,
  output logic [NFU-1:0]    fu_byp,
  output logic [NFU-1:0]    fu_wb,
  output logic [NFU*EW-1:0] fu_wb_elem
);
  logic           busy_q;
  logic [VLW-1:0] vl_q, vl_in;
  chain_mode_e    mode_q;
  logic [NFU-1:0] dep_q, dep_d;
  logic           accept, finished;

  logic [NFU-1:0] iss, go, done_iss, wbv, pbusy, byp;
  logic [EW-1:0]  el  [NFU];
  logic [EW-1:0]  wbe [NFU];

  assign cmd_ready = !busy_q;
  assign accept    = cmd_valid && !busy_q;
  assign vl_in     = (cmd_vl > VLW'(VLMAX)) ? VLW'(VLMAX) : cmd_vl;
  assign finished  = (&done_iss) && !(|pbusy);

  always_comb begin
    dep_d = '0;
    for (int k = 1; k < NFU; k++)
      dep_d[k] = (cmd_src[k*RW +: RW] == cmd_dst[(k-1)*RW +: RW]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      vl_q   <= '0;
      mode_q <= CHAIN_RF;
      dep_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      vl_q   <= vl_in;
      mode_q <= chain_mode_e'(cmd_mode);
      dep_q  <= dep_d;
    end else if (busy_q && finished) begin
      busy_q <= 1'b0;
    end
  end

  for (genvar k = 0; k < NFU; k++) begin : g_fu
    if (k == 0) begin : g_head
      assign go[k]  = 1'b1;
      assign byp[k] = 1'b0;
    end else begin : g_chain
      logic written, fwd_hit;
      vchain_board #(.VLMAX(VLMAX), .EW(EW)) board_i (
        .clk(clk), .rst_n(rst_n), .clr(accept),
        .set_v(wbv[k-1]), .set_e(wbe[k-1]),
        .rd_e(el[k]), .rd_bit(written)
      );
      assign fwd_hit = (mode_q == CHAIN_BYP) && wbv[k-1] && (wbe[k-1] == el[k]);
      assign go[k]   = !dep_q[k] || written || fwd_hit;
      assign byp[k]  = iss[k] && dep_q[k] && !written && fwd_hit;
    end

    vchain_unit_seq #(.VLMAX(VLMAX), .LAT(LAT), .EW(EW), .VLW(VLW)) seq_i (
      .clk(clk), .rst_n(rst_n), .start(accept), .en(busy_q), .vl(vl_q),
      .go(go[k]), .issue(iss[k]), .elem(el[k]), .all_issued(done_iss[k]),
      .wb_v(wbv[k]), .wb_e(wbe[k]), .pipe_busy(pbusy[k])
    );

    assign fu_elem[k*EW +: EW]    = el[k];
    assign fu_wb_elem[k*EW +: EW] = wbe[k];
  end

  assign fu_issue = iss;
  assign fu_byp   = byp;
  assign fu_wb    = wbv;
endmodule

// File: rtl/vchain_ctrl_chk.sv
module vchain_ctrl_chk #(
  parameter int NFU   = 3,
  parameter int VLMAX = 8,
  parameter int LAT   = 3,
  parameter int RW    = 5,
  localparam int EW   = (VLMAX > 1) ? $clog2(VLMAX) : 1,
  localparam int VLW  = $clog2(VLMAX + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [NFU*RW-1:0] cmd_src,
  input logic [NFU*RW-1:0] cmd_dst,
  input logic [NFU-1:0]    fu_issue,
  input logic [NFU*EW-1:0] fu_elem,
  input logic [NFU-1:0]    fu_byp,
  input logic [NFU-1:0]    fu_wb,
  input logic [NFU*EW-1:0] fu_wb_elem
);
  logic [VLW-1:0] nxt_q [NFU];
  logic [VLW-1:0] wbn_q [NFU];
  logic [NFU-1:0] dep_q;
  logic           acc;

  assign acc = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dep_q <= '0;
      for (int k = 0; k < NFU; k++) begin
        nxt_q[k] <= '0;
        wbn_q[k] <= '0;
      end
    end else if (acc) begin
      dep_q <= '0;
      for (int k = 0; k < NFU; k++) begin
        nxt_q[k] <= '0;
        wbn_q[k] <= '0;
        if (k > 0) dep_q[k] <= (cmd_src[k*RW +: RW] == cmd_dst[(k-1)*RW +: RW]);
      end
    end else begin
      for (int k = 0; k < NFU; k++) begin
        if (fu_issue[k]) nxt_q[k] <= nxt_q[k] + VLW'(1);
        if (fu_wb[k])    wbn_q[k] <= wbn_q[k] + VLW'(1);
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (fu_issue == '0 && fu_wb == '0)); // R2

  for (genvar k = 0; k < NFU; k++) begin : g_chk
    AST_ISSUE_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      fu_issue[k] |-> (fu_elem[k*EW +: EW] == nxt_q[k][EW-1:0])); // R8
    AST_WB_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      fu_wb[k] |-> (fu_wb_elem[k*EW +: EW] == wbn_q[k][EW-1:0])); // R7
    if (k > 0) begin : g_dep
      AST_BYP_ON_PRODUCER_WB: assert property (@(posedge clk) disable iff (!rst_n)
        fu_byp[k] |-> (fu_wb[k-1] && fu_wb_elem[(k-1)*EW +: EW] == fu_elem[k*EW +: EW])); // R4
      AST_CONSUMER_NOT_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (fu_issue[k] && dep_q[k]) |->
          (fu_byp[k] || (wbn_q[k-1] > VLW'(fu_elem[k*EW +: EW])))); // R8
    end
  end
endmodule

bind vchain_ctrl vchain_ctrl_chk #(.NFU(NFU), .VLMAX(VLMAX), .LAT(LAT), .RW(RW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_src(cmd_src), .cmd_dst(cmd_dst), .fu_issue(fu_issue), .fu_elem(fu_elem),
  .fu_byp(fu_byp), .fu_wb(fu_wb), .fu_wb_elem(fu_wb_elem)
);

// File: tb/vchain_ctrl_tb_top.sv
`timescale 1ns/1ps
module vchain_ctrl_tb_top;
  localparam int NFU = 3, VLMAX = 8, LAT = 3, RW = 5;
  localparam int EW = $clog2(VLMAX), VLW = $clog2(VLMAX + 1);

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_mode = 0;
  logic [VLW-1:0] cmd_vl = '0;
  logic [NFU*RW-1:0] cmd_src = '0, cmd_dst = '0;
  logic cmd_ready;
  logic [NFU-1:0] fu_issue, fu_byp, fu_wb;
  logic [NFU*EW-1:0] fu_elem, fu_wb_elem;

  always #2.5 clk = ~clk;

  vchain_ctrl #(.NFU(NFU), .VLMAX(VLMAX), .LAT(LAT), .RW(RW)) dut_i (.*);

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  int sched [NFU][VLMAX];
  bit dep_m [NFU];
  int vl_m = 0, acc_m = -100, ready_at = 0;
  bit byp_m = 0;
  string cur_tag = "R1";

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d cycle=%0d", tag, what, act, exp, cyc);
    end
  endtask

  function automatic string unit_tag(int k);
    if (k == 0) return "R3";
    if (!dep_m[k]) return "R6";
    return byp_m ? "R4" : "R5";
  endfunction

  task automatic compare_all();
    int exp_rdy;
    exp_rdy = (cyc >= acc_m + 1 && cyc < ready_at) ? 0 : 1;
    chk({cur_tag, "/R2"}, "cmd_ready", cmd_ready, exp_rdy);
    for (int k = 0; k < NFU; k++) begin
      int ei = -1, we = -1;
      for (int i = 0; i < vl_m; i++) begin
        if (sched[k][i] == cyc) ei = i;
        if (sched[k][i] + LAT == cyc) we = i;
      end
      chk({cur_tag, "/", unit_tag(k)}, $sformatf("u%0d issue", k), fu_issue[k], ei >= 0);
      if (ei >= 0) chk({cur_tag, "/R8"}, $sformatf("u%0d elem", k), fu_elem[k*EW +: EW], ei);
      chk({cur_tag, "/", unit_tag(k)}, $sformatf("u%0d byp", k), fu_byp[k],
          (ei >= 0 && dep_m[k] && byp_m) ? 1 : 0);
      chk({cur_tag, "/R7"}, $sformatf("u%0d wb", k), fu_wb[k], we >= 0);
      if (we >= 0) chk({cur_tag, "/R7"}, $sformatf("u%0d wb_elem", k), fu_wb_elem[k*EW +: EW], we);
    end
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic plan(int a, int vl, bit byp, bit d1, bit d2);
    int last;
    vl_m = (vl > VLMAX) ? VLMAX : vl;
    byp_m = byp; dep_m[0] = 0; dep_m[1] = d1; dep_m[2] = d2;
    acc_m = a;
    for (int k = 0; k < NFU; k++)
      for (int i = 0; i < VLMAX; i++) sched[k][i] = -1000;
    last = -1;
    for (int k = 0; k < NFU; k++)
      for (int i = 0; i < vl_m; i++) begin
        if (k == 0 || !dep_m[k]) sched[k][i] = a + 1 + i;
        else begin
          int t, p;
          t = (i == 0) ? a + 1 : sched[k][i-1] + 1;
          p = sched[k-1][i] + LAT + (byp ? 0 : 1);
          sched[k][i] = (t > p) ? t : p;
        end
        if (sched[k][i] > last) last = sched[k][i];
      end
    ready_at = (vl_m == 0) ? a + 2 : last + LAT + 2;
  endtask

  // Encoding: unit k at [k*RW +: RW]; dst = 1,2,3; dependency when src[k] == dst[k-1].
  task automatic run_cmd(int vl, bit byp, bit d1, bit d2, bit hold, string tag);
    cur_tag = tag;
    cmd_vl  = VLW'(vl);
    cmd_mode = byp;
    cmd_dst = {RW'(3), RW'(2), RW'(1)};
    cmd_src = {(d2 ? RW'(2) : RW'(8)), (d1 ? RW'(1) : RW'(7)), RW'(9)};
    cmd_valid = 1;
    plan(cyc, vl, byp, d1, d2);
    do begin
      step();
      cmd_valid = (hold && !cmd_ready) ? 1'b1 : 1'b0;
      if (hold) begin
        cmd_vl = VLW'(2); cmd_mode = ~byp;
        cmd_src = {RW'(20), RW'(21), RW'(22)};
      end
    end while (!cmd_ready);
    cmd_valid = 0;
  endtask

  initial begin
    for (int k = 0; k < NFU; k++) begin
      dep_m[k] = 0;
      for (int i = 0; i < VLMAX; i++) sched[k][i] = -1000;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "cmd_ready", cmd_ready, 1);
    chk("R1", "fu_issue", fu_issue, 0);
    chk("R1", "fu_byp", fu_byp, 0);
    chk("R1", "fu_wb", fu_wb, 0);
    run_cmd(8, 1, 1, 1, 0, "R4");   // bypass chain, three units
    run_cmd(8, 0, 1, 1, 0, "R5");   // register-file chain
    run_cmd(4, 1, 1, 0, 0, "R6");   // third unit independent
    run_cmd(5, 0, 0, 1, 0, "R6");   // middle unit independent, third chains on it
    run_cmd(15, 1, 1, 1, 0, "R9");  // clamped to VLMAX
    run_cmd(0, 1, 1, 1, 0, "R9");   // empty vector
    run_cmd(6, 1, 1, 1, 1, "R10");  // new command held while busy
    run_cmd(3, 0, 1, 1, 0, "R8");   // back-to-back after held command
    repeat (3) step();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule